// File: doc/BRIEF.md
# Oversampled Serial Receiver with Line Error Flags

This block receives characters from an asynchronous serial line. An external generator supplies a one-cycle sample tick at sixteen times the bit rate. On each tick the receiver looks at a synchronised copy of the line. A falling edge starts a frame. The start bit is confirmed at its centre. The receiver then takes eight data bits, least significant first, an optional ninth bit that it samples and discards, and finally a stop bit. When the stop bit is sampled, the assembled byte goes into a receive buffer and a ready flag is raised.

Three error conditions are tracked next to the data. An overrun flag latches when a byte lands while ready is still set; the older byte is replaced. This flag stays set until software clears it. A framing flag shows whether the most recent stop bit was sampled low. A line-break flag latches once the line has been sampled low on more than 168 consecutive ticks, which is ten and a half bit times. The next frame with a good stop bit clears it.

Software reaches the block through a two-entry register port. Select 0 returns the received byte. Select 1 returns the status byte, and a write to it acknowledges the ready and overrun flags.

Top module: `serial_rx_status`

## Requirements
- R1: After reset the data register reads 0x00 and the status register reads 0x00. Status bits: bit 0 ready, bit 1 overrun, bit 2 framing, bit 3 break, bits 7:4 always 0.
- R2: A frame made of a low start bit, eight data bits sent least significant first and a stop bit delivers its byte to the data register (select 0) and sets the ready bit. Each bit lasts 16 ticks, and every bit is sampled at its centre.
- R3: A low pulse that has ended by the start-bit centre sample (8 ticks after the first low sample) is dropped: no byte is delivered and ready stays 0.
- R4: With the ninth-bit enable high, one extra bit follows the data bits and comes before the stop bit. Its value does not reach the data register, and the stop bit is taken from the bit after it.
- R5: When a frame completes while ready is still 1, the overrun bit becomes 1 and the data register holds the newer byte.
- R6: The overrun bit stays 1 until a status write with bit 1 equal to 0. A status write with bit 1 equal to 1 leaves it unchanged.
- R7: At each stop-bit sample the framing bit takes the inverse of the sampled stop level. It is read-only: status writes do not change it.
- R8: The break bit becomes 1 once the line has been sampled low on at least 169 consecutive ticks. A run of 168 ticks leaves it at 0. It returns to 0 at the stop sample of a frame whose stop bit is high.
- R9: A status write with bit 0 equal to 0 clears ready. A write with bit 0 equal to 1 leaves ready unchanged.
- R10: Writes to the data register (select 0) do not change its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleTick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxLine | input | 1 | Asynchronous serial input, idle high |
| ninthEn | input | 1 | Frame carries a ninth bit before the stop bit |
| regSel | input | 1 | Register select: 0 data, 1 status |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Combinational read data of the selected register |

## Verification
The line passes through a two-stage synchroniser before the receiver sees it. For that reason the bench changes the line only just after a tick has been consumed, and it keeps each level for whole groups of 16 ticks, so every level is settled at least two clocks before the next tick samples it. The byte and the ready, overrun and framing flags update on the clock edge that takes the stop-bit sample. That edge is 152 ticks after the first low sample, or 168 ticks when the ninth bit is enabled. The break flag updates on the edge of the 169th consecutive low sample. The bench reads the registers only after at least four idle ticks have followed the stop bit, and it reads them half a clock after writes, so each result is already due when it is sampled.

// File: rtl/rx_status_pkg.sv
package rx_status_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_NINTH,
    ST_STOP,
    ST_DRAIN
  } rx_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic frameDone;
  } rx_strobe_t;

  typedef struct packed {
    logic brk;
    logic frameErr;
    logic ovr;
    logic ready;
  } rx_flags_t;

endpackage

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import rx_status_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 16,
  parameter int unsigned DATA_BITS  = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       lineIn,
  input  logic       ninthEn,
  output rx_strobe_t strobes
);

  localparam int unsigned CW = $clog2(OVERSAMPLE);
  localparam int unsigned BW = $clog2(DATA_BITS + 1);
  localparam logic [CW-1:0] LAST_TICK = CW'(OVERSAMPLE - 1);
  localparam logic [CW-1:0] MID_TICK  = CW'(OVERSAMPLE / 2 - 1);
  localparam logic [BW-1:0] LAST_BIT  = BW'(DATA_BITS - 1);

  rx_state_t     state;
  logic [CW-1:0] tickCnt;
  logic [BW-1:0] bitIdx;
  logic          bitEnd;

  assign bitEnd = (tickCnt == LAST_TICK);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else if (sampleTick) begin
      case (state)
        ST_IDLE: begin
          if (!lineIn) begin
            state   <= ST_START;
            tickCnt <= '0;
          end
        end
        ST_START: begin
          if (tickCnt == MID_TICK) begin
            tickCnt <= '0;
            bitIdx  <= '0;
            state   <= lineIn ? ST_IDLE : ST_DATA;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (bitEnd) begin
            tickCnt <= '0;
            if (bitIdx == LAST_BIT) state <= ninthEn ? ST_NINTH : ST_STOP;
            else bitIdx <= bitIdx + 1'b1;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_NINTH: begin
          if (bitEnd) begin
            tickCnt <= '0;
            state   <= ST_STOP;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (bitEnd) begin
            tickCnt <= '0;
            state   <= lineIn ? ST_IDLE : ST_DRAIN;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (lineIn) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.shiftIn   = sampleTick && (state == ST_DATA) && bitEnd;
    strobes.frameDone = sampleTick && (state == ST_STOP) && bitEnd;
  end

endmodule

// File: rtl/rx_datapath.sv
module rx_datapath
  import rx_status_pkg::*;
#(
  parameter int unsigned DATA_BITS   = 8,
  parameter int unsigned BREAK_TICKS = 168
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleTick,
  input  logic                 lineIn,
  input  rx_strobe_t           strobes,
  input  logic                 clrReady,
  input  logic                 clrOvr,
  output logic [DATA_BITS-1:0] rxData,
  output rx_flags_t            flags
);

  localparam int unsigned LW = $clog2(BREAK_TICKS + 2);
  localparam logic [LW-1:0] RUN_MAX = LW'(BREAK_TICKS + 1);
  localparam logic [LW-1:0] RUN_TRIP = LW'(BREAK_TICKS);

  logic [DATA_BITS-1:0] shiftQ;
  logic [LW-1:0]        lowRun;

  always_ff @(posedge clk) begin
    if (!rstN) shiftQ <= '0;
    else if (strobes.shiftIn) shiftQ <= {lineIn, shiftQ[DATA_BITS-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData         <= '0;
      flags.ready    <= 1'b0;
      flags.ovr      <= 1'b0;
      flags.frameErr <= 1'b0;
    end else begin
      if (strobes.frameDone) begin
        rxData         <= shiftQ;
        flags.ready    <= 1'b1;
        flags.frameErr <= !lineIn;
      end else if (clrReady) begin
        flags.ready <= 1'b0;
      end
      if (strobes.frameDone && flags.ready) flags.ovr <= 1'b1;
      else if (clrOvr) flags.ovr <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowRun    <= '0;
      flags.brk <= 1'b0;
    end else begin
      if (sampleTick) begin
        if (lineIn) lowRun <= '0;
        else if (lowRun != RUN_MAX) lowRun <= lowRun + 1'b1;
      end
      if (sampleTick && !lineIn && lowRun == RUN_TRIP) flags.brk <= 1'b1;
      else if (strobes.frameDone && lineIn) flags.brk <= 1'b0;
    end
  end

endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
  import rx_status_pkg::*;
#(
  parameter int unsigned OVERSAMPLE  = 16,
  parameter int unsigned DATA_BITS   = 8,
  parameter int unsigned BREAK_TICKS = 168,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       rxLine,
  input  logic       ninthEn,
  input  logic       regSel,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData
);

  localparam int unsigned REG_W = 8;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lineSync;
  rx_strobe_t             strobes;
  rx_flags_t              flags;
  logic [DATA_BITS-1:0]   rxData;
  logic                   clrReady;
  logic                   clrOvr;
  logic                   unusedWrBits;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '1;
    else syncQ <= {syncQ[SYNC_STAGES-2:0], rxLine};
  end
  assign lineSync = syncQ[SYNC_STAGES-1];

  assign clrReady     = regWrEn && regSel && !regWrData[0];
  assign clrOvr       = regWrEn && regSel && !regWrData[1];
  assign unusedWrBits = ^regWrData[7:2];

  rx_ctrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_BITS(DATA_BITS)) i_ctrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .lineIn(lineSync),
    .ninthEn(ninthEn), .strobes(strobes)
  );

  rx_datapath #(.DATA_BITS(DATA_BITS), .BREAK_TICKS(BREAK_TICKS)) i_dp (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .lineIn(lineSync),
    .strobes(strobes), .clrReady(clrReady), .clrOvr(clrOvr),
    .rxData(rxData), .flags(flags)
  );

  always_comb begin
    if (regSel) regRdData = {4'b0000, flags.brk, flags.frameErr, flags.ovr, flags.ready};
    else regRdData = REG_W'(rxData);
  end

endmodule

// File: rtl/serial_rx_status_checker.sv
module serial_rx_status_checker #(
  parameter int unsigned DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 frameDone,
  input logic                 lineSync,
  input logic                 clrOvr,
  input logic                 ready,
  input logic                 ovr,
  input logic                 frameErr,
  input logic                 brk,
  input logic [DATA_BITS-1:0] rxData
);

  assert_ready_on_frame_R2: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> ready);

  assert_ovr_on_full_R5: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && ready |=> ovr);

  assert_ovr_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    ovr && !clrOvr |=> ovr);

  assert_ovr_only_by_frame_R6: assert property (@(posedge clk) disable iff (!rstN)
    !ovr && !frameDone |=> !ovr);

  assert_frame_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> frameErr == !$past(lineSync));

  assert_frame_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !frameDone |=> $stable(frameErr));

  assert_break_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && lineSync |=> !brk);

  assert_data_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !frameDone |=> $stable(rxData));

endmodule

bind serial_rx_status serial_rx_status_checker #(.DATA_BITS(DATA_BITS)) i_checker (
  .clk(clk), .rstN(rstN), .frameDone(strobes.frameDone), .lineSync(lineSync),
  .clrOvr(clrOvr), .ready(flags.ready), .ovr(flags.ovr), .frameErr(flags.frameErr),
  .brk(flags.brk), .rxData(rxData)
);

// File: tb/test_serial_rx_status.sv
module test_serial_rx_status;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxLine = 1'b1;
  logic       ninthEn = 1'b0;
  logic       regSel = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic [1:0] divCnt = 2'd0;
  logic       sampleTick;

  int checks = 0;
  int failures = 0;

  logic       expReady = 0, expOvr = 0, expFe = 0, expBrk = 0;
  logic [7:0] expData = 8'h00;

  always #4 clk = ~clk;
  always @(posedge clk) divCnt <= divCnt + 2'd1;
  assign sampleTick = (divCnt == 2'd3);

  serial_rx_status i_serial_rx_status (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .ninthEn(ninthEn), .regSel(regSel), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic logic [7:0] expStatus();
    return {4'b0000, expBrk, expFe, expOvr, expReady};
  endfunction

  task automatic waitTicks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!sampleTick) @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic sel, output logic [7:0] v);
    @(negedge clk);
    regSel = sel;
    #1 v = regRdData;
  endtask

  task automatic writeReg(input logic sel, input logic [7:0] d);
    @(negedge clk);
    regSel = sel;
    regWrData = d;
    regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic statusWrite(input logic [7:0] d);
    writeReg(1'b1, d);
    if (!d[0]) expReady = 1'b0;
    if (!d[1]) expOvr = 1'b0;
  endtask

  task automatic checkRegs(input string req);
    logic [7:0] v;
    readReg(1'b0, v);
    check(req, v, expData);
    readReg(1'b1, v);
    check(req, v, expStatus());
  endtask

  task automatic sendFrame(input logic [7:0] b, input logic nine, input logic nineVal,
                           input logic stopVal);
    ninthEn = nine;
    rxLine = 1'b0;
    waitTicks(16);
    for (int i = 0; i < 8; i++) begin
      rxLine = b[i];
      waitTicks(16);
    end
    if (nine) begin
      rxLine = nineVal;
      waitTicks(16);
    end
    rxLine = stopVal;
    waitTicks(16);
    rxLine = 1'b1;
    waitTicks(4);
    if (expReady) expOvr = 1'b1;
    expReady = 1'b1;
    expData = b;
    expFe = !stopVal;
    if (stopVal) expBrk = 1'b0;
    else if (nine && b == 8'h00 && !nineVal) expBrk = 1'b1;  // 176 low samples
  endtask

  // Line held low for n samples; frame completes at sample 152 (no ninth bit)
  task automatic holdLow(input int n);
    ninthEn = 1'b0;
    rxLine = 1'b0;
    waitTicks(n);
    rxLine = 1'b1;
    waitTicks(20);
    if (n >= 153) begin
      if (expReady) expOvr = 1'b1;
      expReady = 1'b1;
      expData = 8'h00;
      expFe = 1'b1;
    end
    if (n >= 169) expBrk = 1'b1;
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    waitTicks(4);

    // R1: reset values
    checkRegs("R1");

    // R2: basic frame
    sendFrame(8'hA5, 1'b0, 1'b0, 1'b1);
    checkRegs("R2");
    sendFrame(8'h01, 1'b0, 1'b0, 1'b1);
    readReg(1'b0, v);
    check("R2", v, 8'h01);
    statusWrite(8'h02);

    // R9: ready cleared by write of 0 to bit 0, write of 1 keeps it
    checkRegs("R9");
    sendFrame(8'h80, 1'b0, 1'b0, 1'b1);
    statusWrite(8'h03);
    checkRegs("R9");
    statusWrite(8'h02);

    // R3: short low glitch dropped
    rxLine = 1'b0;
    waitTicks(4);
    rxLine = 1'b1;
    waitTicks(40);
    checkRegs("R3");

    // R10: data register writes ignored
    writeReg(1'b0, 8'hFF);
    checkRegs("R10");

    // R4: ninth bit present, low, must not be taken as the stop bit
    sendFrame(8'h3C, 1'b1, 1'b0, 1'b1);
    checkRegs("R4");
    statusWrite(8'h02);
    sendFrame(8'hC3, 1'b1, 1'b1, 1'b1);
    checkRegs("R4");

    // R5: overrun while ready still set
    sendFrame(8'h11, 1'b0, 1'b0, 1'b1);
    checkRegs("R5");

    // R6: overrun sticky against write of 1, cleared by write of 0
    statusWrite(8'hFF);
    checkRegs("R6");
    statusWrite(8'h01);
    checkRegs("R6");
    statusWrite(8'h00);

    // R7: framing flag
    sendFrame(8'h55, 1'b0, 1'b0, 1'b0);
    checkRegs("R7");
    statusWrite(8'h00);
    statusWrite(8'hFB);
    checkRegs("R7");
    sendFrame(8'h66, 1'b0, 1'b0, 1'b1);
    checkRegs("R7");
    statusWrite(8'h00);

    // R8: break threshold boundary
    holdLow(168);
    checkRegs("R8");
    statusWrite(8'h00);
    holdLow(169);
    checkRegs("R8");
    statusWrite(8'h00);
    sendFrame(8'h00, 1'b1, 1'b0, 1'b0);
    checkRegs("R8");
    sendFrame(8'h5A, 1'b0, 1'b0, 1'b1);
    checkRegs("R8");
    statusWrite(8'h00);

    // Random frames: R2 R4 R5 R6 R7 R9
    for (int k = 0; k < 28; k++) begin
      logic [7:0] b;
      logic nine, nv, sv;
      int act;
      b = 8'($urandom);
      nine = 1'($urandom);
      nv = 1'($urandom);
      sv = ($urandom % 5) != 0;
      sendFrame(b, nine, nv, sv);
      checkRegs("R2");
      act = $urandom % 4;
      if (act == 1) statusWrite(8'h02);
      else if (act == 2) statusWrite(8'h00);
      else if (act == 3) statusWrite(8'h03);
      readReg(1'b1, v);
      check("R6", v, expStatus());
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule